// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block converts a stream of host-written bytes into asynchronous serial frames on a single output line. Bytes go into a 16-entry queue. A frame state machine takes them from the queue into a shift register. Each frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts one period of an external bit-tick enable. Baud-rate generation sits outside the block; the host drives the one-cycle `bit_tick` pulse.

The state machine has five states: `S_IDLE`, `S_START`, `S_DATA`, `S_PARITY` and `S_STOP`. It moves only on a bit tick, along these transitions:
- `S_IDLE` to `S_START` when the queue holds a byte.
- `S_START` to `S_DATA`.
- `S_DATA` to `S_PARITY` after the last data bit when parity is on, or `S_DATA` to `S_STOP` when parity is off.
- `S_PARITY` to `S_STOP`.
- `S_STOP` to `S_STOP` for a second stop bit.
- `S_STOP` to `S_START` when a byte is already loaded for the next frame.
- `S_STOP` to `S_IDLE` otherwise.

The queue is examined on entry to `S_STOP`. If it holds a byte, that byte goes straight into the shift register, so the next start bit follows the stop bits with no mark gap.

Two sticky status flags report to the host. The first is a low-water flag with a selectable threshold. The second is a transmit-end flag, raised when the stop phase begins with an empty queue. An interrupt output follows the low-water flag when enabled.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `end_flag` is 1, `low_flag` is 1, `ovf` is 0, and `irq` is 0 while `irq_en` is 0.
- R2: A frame is one 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits of value 1. `txd` changes only in the cycle after a clock edge at which `bit_tick` was 1, so each bit lasts exactly one tick period.
- R3: With `cfg_seven`=1, only bits 0 to 6 of the byte are sent. Bit 7 has no effect on the line, and parity is formed over the seven sent bits only.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 makes the count of ones in data plus parity even; `cfg_par_odd`=1 makes it odd. With `cfg_par_en`=0, no parity bit is sent.
- R5: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two.
- R6: When the queue holds a byte at the start of the stop phase, that byte's start bit comes directly after the last stop bit, with no mark bit between.
- R7: With the queue empty, `txd` holds 1. A byte written to an idle transmitter starts its start bit at the next bit tick.
- R8: The queue holds 16 bytes and sends them in write order. A write while full is dropped, and `ovf` is 1 for exactly the cycle after that write.
- R9: `cfg_trig` codes 0, 1, 2 and 3 select the thresholds 0, 2, 4 and 8 bytes. `low_flag` is set whenever occupancy is at or below the threshold. Once set, it stays set until a `clr_low` pulse, and the pulse clears it only when occupancy is above the threshold.
- R10: `irq` is 1 exactly when `low_flag` and `irq_en` are both 1.
- R11: `end_flag` is set when the stop phase begins with an empty queue. It is cleared by `clr_end` or by an accepted write, and an accepted write wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 inserts a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_trig | input | 2 | Low-water threshold code (0,2,4,8 bytes) |
| irq_en | input | 1 | Interrupt enable |
| clr_low | input | 1 | Clear pulse for the low-water flag |
| clr_end | input | 1 | Clear pulse for the transmit-end flag |
| txd | output | 1 | Serial output line |
| low_flag | output | 1 | Sticky low-occupancy flag |
| end_flag | output | 1 | Sticky transmit-end flag |
| ovf | output | 1 | One-cycle pulse for a dropped write |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are the queue boundaries: a write to a full queue, and a run of frames chained through the stop-phase hand-off. The bench first halts the bit ticks. It then fills the queue to exactly 16 entries and issues one extra write, and checks the low-water flag against each threshold while occupancy is frozen. After that it releases the ticks and compares the whole recorded bit stream against the concatenated expected frames. Any mark bit inserted between frames, or any byte dropped or duplicated, breaks the match.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PARITY = 3'd3,
        S_STOP   = 3'd4
    } tx_state_t;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int DW  = 8,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          cfg_seven,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    input  logic          q_empty,
    input  logic [DW-1:0] q_data,
    output logic          q_pop,
    output logic          end_set,
    output logic          txd,
    output tx_state_t     state
);
    tx_state_t     st_n;
    logic [DW-1:0] shreg, sh_n;
    logic [IW-1:0] idx, idx_n, last_idx;
    logic          par_bit, par_n;
    logic          stop2, stop2_n;
    logic          have_next, next_n;
    logic          to_stop;

    function automatic logic calc_par(input logic [DW-1:0] d, input logic seven, input logic odd);
        logic [DW-1:0] m;
        m = d;
        if (seven) m[DW-1] = 1'b0;
        return (^m) ^ odd;
    endfunction

    assign last_idx = cfg_seven ? IW'(DW-2) : IW'(DW-1);

    // next-state process
    always_comb begin
        st_n    = state;
        sh_n    = shreg;
        idx_n   = idx;
        par_n   = par_bit;
        stop2_n = stop2;
        next_n  = have_next;
        q_pop   = 1'b0;
        end_set = 1'b0;
        to_stop = 1'b0;
        if (bit_tick) begin
            unique case (state)
                S_IDLE: begin
                    if (!q_empty) begin
                        q_pop = 1'b1;
                        sh_n  = q_data;
                        par_n = calc_par(q_data, cfg_seven, cfg_par_odd);
                        st_n  = S_START;
                    end
                end
                S_START: begin
                    st_n  = S_DATA;
                    idx_n = '0;
                end
                S_DATA: begin
                    if (idx == last_idx) begin
                        if (cfg_par_en) st_n = S_PARITY;
                        else            to_stop = 1'b1;
                    end else begin
                        sh_n  = shreg >> 1;
                        idx_n = idx + 1'b1;
                    end
                end
                S_PARITY: to_stop = 1'b1;
                S_STOP: begin
                    if (cfg_two_stop && !stop2) stop2_n = 1'b1;
                    else st_n = have_next ? S_START : S_IDLE;
                end
                default: st_n = S_IDLE;
            endcase
            if (to_stop) begin
                st_n    = S_STOP;
                stop2_n = 1'b0;
                if (!q_empty) begin
                    q_pop  = 1'b1;
                    sh_n   = q_data;
                    par_n  = calc_par(q_data, cfg_seven, cfg_par_odd);
                    next_n = 1'b1;
                end else begin
                    next_n  = 1'b0;
                    end_set = 1'b1;
                end
            end
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            shreg     <= '0;
            idx       <= '0;
            par_bit   <= 1'b0;
            stop2     <= 1'b0;
            have_next <= 1'b0;
        end else begin
            state     <= st_n;
            shreg     <= sh_n;
            idx       <= idx_n;
            par_bit   <= par_n;
            stop2     <= stop2_n;
            have_next <= next_n;
        end
    end

    // output process
    always_comb begin
        unique case (state)
            S_START:  txd = 1'b0;
            S_DATA:   txd = shreg[0];
            S_PARITY: txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic [1:0]    trig,
    input  logic          wr_en,
    input  logic          clr_low,
    input  logic          clr_end,
    input  logic          end_set,
    input  logic          irq_en,
    output logic          low_flag,
    output logic          end_flag,
    output logic          ovf,
    output logic          irq
);
    logic [CW-1:0] level;
    logic          low_hit, wr_ok;

    always_comb begin
        unique case (trig)
            2'd0: level = CW'(0);
            2'd1: level = CW'(2);
            2'd2: level = CW'(4);
            default: level = CW'(8);
        endcase
    end

    assign low_hit = (count <= level);
    assign wr_ok   = wr_en && !full;
    assign irq     = low_flag && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_flag <= 1'b1;
            end_flag <= 1'b1;
            ovf      <= 1'b0;
        end else begin
            if (low_hit)      low_flag <= 1'b1;
            else if (clr_low) low_flag <= 1'b0;
            if (wr_ok || clr_end) end_flag <= 1'b0;
            else if (end_set)     end_flag <= 1'b1;
            ovf <= wr_en && full;
        end
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cfg_seven,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    input  logic [1:0]    cfg_trig,
    input  logic          irq_en,
    input  logic          clr_low,
    input  logic          clr_end,
    output logic          txd,
    output logic          low_flag,
    output logic          end_flag,
    output logic          ovf,
    output logic          irq
);
    logic [DW-1:0] q_head;
    logic [CW-1:0] q_count;
    logic          q_full, q_empty, q_pop, end_set;
    tx_state_t     fsm_state;

    sertx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(q_pop), .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
    );

    sertx_frame #(.DW(DW)) u_frame (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_seven(cfg_seven),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .q_empty(q_empty), .q_data(q_head), .q_pop(q_pop), .end_set(end_set),
        .txd(txd), .state(fsm_state)
    );

    sertx_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(q_count), .full(q_full), .trig(cfg_trig),
        .wr_en(wr_en), .clr_low(clr_low), .clr_end(clr_end), .end_set(end_set),
        .irq_en(irq_en), .low_flag(low_flag), .end_flag(end_flag), .ovf(ovf), .irq(irq)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_tick,
    input logic          wr_en,
    input logic [1:0]    cfg_trig,
    input logic          txd,
    input logic          low_flag,
    input logic          end_flag,
    input logic          ovf,
    input logic [CW-1:0] q_count,
    input logic          q_full,
    input tx_state_t     fsm_state
);
    logic [CW-1:0] thr;
    assign thr = (cfg_trig == 2'd0) ? CW'(0) : (cfg_trig == 2'd1) ? CW'(2) :
                 (cfg_trig == 2'd2) ? CW'(4) : CW'(8);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));
    a_r8_ovf_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q_full) |=> ovf);
    a_r2_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(txd));
    a_r7_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_IDLE) |-> txd);
    a_r11_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !q_full) |=> !end_flag);
    a_r9_low_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count <= thr) |=> low_flag);
endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .cfg_trig(cfg_trig),
    .txd(txd), .low_flag(low_flag), .end_flag(end_flag), .ovf(ovf),
    .q_count(q_count), .q_full(q_full), .fsm_state(fsm_state)
);

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic       irq_en = 1'b0, clr_low = 1'b0, clr_end = 1'b0;
    logic       txd, low_flag, end_flag, ovf, irq;

    int   tests = 0, fails = 0;
    logic tick_on = 1'b0;
    int   div = 0;
    logic rec[$];
    logic exp_q[$];

    sertx_top dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_trig(cfg_trig), .irq_en(irq_en),
        .clr_low(clr_low), .clr_end(clr_end), .txd(txd), .low_flag(low_flag),
        .end_flag(end_flag), .ovf(ovf), .irq(irq)
    );

    always #4 clk = ~clk;

    // tick generator and line recorder: a bit is recorded after each ticked edge
    always @(negedge clk) begin
        if (bit_tick) rec.push_back(txd);
        if (tick_on) begin
            div      = (div == TDIV - 1) ? 0 : div + 1;
            bit_tick = (div == 0);
        end else begin
            div      = 0;
            bit_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tick_on = 1'b0;
        wr_en = 1'b0; clr_low = 1'b0; clr_end = 1'b0; irq_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic add_frame(input logic [7:0] d);
        logic [7:0] m;
        int n;
        n = cfg_seven ? 7 : 8;
        m = cfg_seven ? {1'b0, d[6:0]} : d;
        exp_q.push_back(1'b0);
        for (int i = 0; i < n; i++) exp_q.push_back(m[i]);
        if (cfg_par_en) exp_q.push_back((^m) ^ cfg_par_odd);
        exp_q.push_back(1'b1);
        if (cfg_two_stop) exp_q.push_back(1'b1);
    endtask

    task automatic check_stream(input string req);
        int first, bad;
        first = -1; bad = -1;
        for (int i = 0; i < rec.size(); i++) if (first < 0 && rec[i] == 1'b0) first = i;
        if (first < 0 || first + exp_q.size() + 2 > rec.size()) begin
            check({req, " stream length"}, rec.size(), exp_q.size() + 2);
            return;
        end
        for (int k = 0; k < exp_q.size(); k++)
            if (bad < 0 && rec[first + k] != exp_q[k]) bad = k;
        for (int k = 0; k < 2; k++)
            if (bad < 0 && rec[first + exp_q.size() + k] != 1'b1) bad = exp_q.size() + k;
        check({req, " stream first mismatch bit (-1 = none)"}, bad, -1);
    endtask

    task automatic run_frames(input string req, input logic [7:0] bytes[$]);
        tick_on = 1'b0;
        foreach (bytes[i]) wr_byte(bytes[i]);
        rec.delete(); exp_q.delete();
        foreach (bytes[i]) add_frame(bytes[i]);
        tick_on = 1'b1;
        repeat ((exp_q.size() + 6) * TDIV) @(negedge clk);
        check_stream(req);
        check({req, " end_flag after drain (R11)"}, end_flag, 1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 txd", txd, 1);
        check("R1 end_flag", end_flag, 1);
        check("R1 low_flag", low_flag, 1);
        check("R1 ovf", ovf, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_formats();
        do_reset();
        cfg_seven = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
        run_frames("R2 8N1", '{8'hA5});
        do_reset();
        cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
        run_frames("R4 R5 R6 8E2", '{8'h3C, 8'h01, 8'hFE});
        do_reset();
        cfg_seven = 1; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 0;
        run_frames("R3 7O1", '{8'hC3, 8'h80});
        do_reset();
        cfg_seven = 0; cfg_par_en = 1; cfg_par_odd = 1;
        run_frames("R4 8O1", '{8'h00, 8'hFF});
        do_reset();
        cfg_seven = 1; cfg_par_en = 0; cfg_two_stop = 1;
        run_frames("R3 R5 7N2", '{8'hFF, 8'h55});
        cfg_seven = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
    endtask

    task automatic t_idle_start();
        int ones;
        do_reset();
        rec.delete(); exp_q.delete();
        tick_on = 1'b1;
        repeat (10 * TDIV) @(negedge clk);
        ones = 0;
        foreach (rec[i]) ones += rec[i];
        check("R7 idle mark", ones, rec.size());
        wr_byte(8'h96);
        add_frame(8'h96);
        repeat ((exp_q.size() + 6) * TDIV) @(negedge clk);
        check_stream("R7 start from idle");
    endtask

    task automatic t_full();
        logic [7:0] bytes[$];
        do_reset();
        cfg_trig = 2'd3;
        for (int i = 0; i < 16; i++) begin
            bytes.push_back(8'(i * 37 + 5));
            wr_byte(8'(i * 37 + 5));
        end
        check("R8 no ovf at 16", ovf, 0);
        @(negedge clk); clr_low = 1; @(negedge clk); clr_low = 0;
        check("R9 low clear at 16", low_flag, 0);
        irq_en = 1'b1;
        #1 check("R10 irq low off", irq, 0);
        wr_byte(8'hEE);
        check("R8 ovf on full write", ovf, 1);
        @(negedge clk);
        check("R8 ovf one cycle", ovf, 0);
        rec.delete(); exp_q.delete();
        foreach (bytes[i]) add_frame(bytes[i]);
        tick_on = 1'b1;
        repeat ((exp_q.size() + 6) * TDIV) @(negedge clk);
        check_stream("R8 R6 sixteen frames");
        check("R9 low after drain", low_flag, 1);
        check("R10 irq enabled", irq, 1);
        irq_en = 1'b0;
        #1 check("R10 irq masked", irq, 0);
    endtask

    task automatic t_trigger();
        do_reset();
        cfg_trig = 2'd3;
        for (int i = 0; i < 8; i++) wr_byte(8'(i));
        @(negedge clk); clr_low = 1; @(negedge clk); clr_low = 0;
        check("R9 level8 count8 stays", low_flag, 1);
        wr_byte(8'h08);
        @(negedge clk); clr_low = 1; @(negedge clk); clr_low = 0;
        check("R9 level8 count9 clears", low_flag, 0);
        cfg_trig = 2'd2;
        @(negedge clk);
        check("R9 level4 count9 stays clear", low_flag, 0);
        do_reset();
        cfg_trig = 2'd0;
        wr_byte(8'h11);
        @(negedge clk); clr_low = 1; @(negedge clk); clr_low = 0;
        check("R9 level0 count1 clears", low_flag, 0);
        do_reset();
        cfg_trig = 2'd1;
        wr_byte(8'h11); wr_byte(8'h22);
        @(negedge clk); clr_low = 1; @(negedge clk); clr_low = 0;
        check("R9 level2 count2 stays", low_flag, 1);
    endtask

    task automatic t_end();
        do_reset();
        check("R11 end at reset", end_flag, 1);
        wr_byte(8'h42);
        check("R11 write clears end", end_flag, 0);
        rec.delete(); exp_q.delete();
        tick_on = 1'b1;
        repeat (16 * TDIV) @(negedge clk);
        check("R11 end after empty stop", end_flag, 1);
        @(negedge clk); clr_end = 1; @(negedge clk); clr_end = 0;
        check("R11 clr_end clears", end_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_formats();
        t_idle_start();
        t_full();
        t_trigger();
        t_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule